// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block cleans up the active-low external reset pin before the rest of the chip treats it as a reset source. The raw pin passes through a two-flop synchronizer. Its output then goes to one of two filter engines, or past both of them. The first engine counts consecutive bus-clock samples, and software sets the count it needs. The second engine samples only on cycles where the low-power clock enable is high, and it needs three agreeing samples. The filtered level is turned into an active-high reset request. This block does not generate the reset itself.

Which engine drives the request depends on the power mode. In run/wait mode a 2-bit field picks the engine. In stop mode a 1-bit field picks the engine. In low-leakage stop both engines are held idle, and the synchronized pin passes straight through. Any engine that is not in use is held in its cleared state. When it is picked again it starts counting from zero. The two configuration registers are cleared only by power-on reset. Every other reset leaves them unchanged.

Top module: `rstpin_filter`

## Requirements
- R1: The raw pin is synchronized by two flops. When no filter is in use, `rst_req` rises on the second rising clock edge after `pin_n` falls.
- R2: Bus-clock engine: the width field (register offset 5, bits 4:0) holds W. The filtered level changes only after the synchronized pin has held its new level for W+1 consecutive clock samples. A low pulse that lasts W samples or fewer never raises `rst_req`.
- R3: Run/wait select (register offset 4, bits 1:0): 00 means no filter, 01 means the bus-clock engine, 10 means the low-power engine, and 11 acts the same as 00.
- R4: The low-power engine samples only on cycles where `lp_tick` is high. It changes level after 3 consecutive agreeing samples.
- R5: While `stop_mode` is high, the stop select (register offset 4, bit 2) decides the path: 0 means no filter and 1 means the low-power engine. The bus-clock engine is held cleared.
- R6: An engine that is not in use is cleared: its level reads deasserted and its count is zero. When it is picked again, it needs its full sample count.
- R7: While `ll_stop` is high, the low-power engine is held cleared and `rst_req` follows the synchronized pin directly.
- R8: The configuration fields are set to 0 only while `por_n` is low. A low on `rst_n` leaves them unchanged.
- R9: Reads return the control fields at offset 4 and the width at offset 5, with unused bits as 0. All other offsets read 0, and writes to them are ignored.
- R10: `rst_req` is high exactly when the selected path reports the pin low. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset of synchronizer and engines |
| por_n | input | 1 | Synchronous active-low power-on reset, also clears configuration |
| pin_n | input | 1 | Raw external reset pin, active low |
| lp_tick | input | 1 | One-cycle enable marking a low-power clock sample |
| stop_mode | input | 1 | Chip is in a stop mode |
| ll_stop | input | 1 | Chip is in a low-leakage stop mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| rst_req | output | 1 | Filtered reset request, active high |

## Verification
Directed pulses measure the exact edge on which `rst_req` rises for each path: pass-through, the bus-clock engine at the smallest and largest widths, and the low-power engine. Any off-by-one in the synchronizer or the counters shows up as a one-cycle shift. A low pulse one sample shorter than the width tells filtering apart from pass-through. Leaving and re-entering stop or low-leakage stop during a partial count shows whether the engine really restarts or resumes. Random pin runs of varied length are mixed with random tick density, mode changes, register writes and warm resets. Every cycle, these are compared with a bench model, which exposes mid-count width changes and interactions between modes.

// File: rtl/rpf_pkg.sv
// Shared encodings for the reset pin glitch filter.
// Assumes: register field positions are fixed by software; widths are parameters of the top.
package rpf_pkg;
    // Which path feeds the reset request.
    typedef enum logic [1:0] {
        ENG_OFF = 2'd0,
        ENG_BUS = 2'd1,
        ENG_LP  = 2'd2
    } eng_sel_e;

    // Run/wait select codes; code 3 is reserved and treated as off.
    localparam logic [1:0] RUN_CODE_OFF = 2'd0;
    localparam logic [1:0] RUN_CODE_BUS = 2'd1;
    localparam logic [1:0] RUN_CODE_LP  = 2'd2;

    localparam int unsigned RUN_SEL_W = 2;
endpackage

// File: rtl/rpf_sync.sv
// Multi-flop synchronizer for the asynchronous reset pin.
// Assumes: pin idles high (deasserted); reset loads the idle level.
module rpf_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shreg;

    // Shift the raw pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {STAGES{IDLE_LV}};
        else        shreg <= {shreg[STAGES-2:0], d_i};
    end

    assign q_o = shreg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            // R1: output equals the pin two edges earlier.
            p_two_stage_r1: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (q_o == $past(d_i, 2)));
        end
    endgenerate
endmodule

// File: rtl/rpf_count_filter.sv
// Consecutive-sample glitch filter engine.
// Holds a filtered level (1 = pin high/deasserted) and a run counter. On each
// enabled sample that differs from the level, the counter advances; once the
// run reaches need_i the level flips. clr_i forces the idle state.
// Assumes: need_i >= 1; need_i may change at any time (>= compare copes).
module rpf_count_filter #(
    parameter int unsigned NEED_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              smp_i,
    input  logic [NEED_W-1:0] need_i,
    output logic              level_o,
    output logic [NEED_W-1:0] cnt_o
);
    localparam int unsigned EXT_W = NEED_W + 1;

    logic              level_q;
    logic [NEED_W-1:0] cnt_q;
    logic [EXT_W-1:0]  run_next;
    logic              run_done;

    // Length the run would have after counting this sample.
    always_comb begin
        run_next = {1'b0, cnt_q} + EXT_W'(1);
        run_done = (run_next >= {1'b0, need_i});
    end

    // Track the run of disagreeing samples and flip the level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            level_q <= 1'b1;
            cnt_q   <= '0;
        end else if (en_i) begin
            if (smp_i == level_q) begin
                cnt_q <= '0;
            end else if (run_done) begin
                level_q <= smp_i;
                cnt_q   <= '0;
            end else begin
                cnt_q <= run_next[NEED_W-1:0];
            end
        end
    end

    assign level_o = level_q;
    assign cnt_o   = cnt_q;

    // R2: a level change only follows an enabled sample that completed the run.
    p_flip_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr_i) && (level_o != $past(level_o)))
        |-> ($past(en_i) && (({1'b0, $past(cnt_o)} + EXT_W'(1)) >= {1'b0, $past(need_i)})));

    // R6: a cleared engine reads idle on the next cycle.
    p_clear_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (level_o && (cnt_o == '0)));
endmodule

// File: rtl/rpf_cfg_regs.sv
// Filter configuration registers with a byte-wide write/read port.
// Control: run/wait select in bits 1:0, stop select in bit 2. Width: bits WIDTH_W-1:0.
// Assumes: only power-on reset clears the fields; reads are combinational.
module rpf_cfg_regs #(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned WIDTH_W     = 5,
    parameter int unsigned CTRL_OFFSET = 4,
    parameter int unsigned WID_OFFSET  = 5
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic [rpf_pkg::RUN_SEL_W-1:0] run_sel_o,
    output logic                       stop_sel_o,
    output logic [WIDTH_W-1:0]         width_o
);
    import rpf_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_OFFSET);
    localparam logic [ADDR_W-1:0] WID_A     = ADDR_W'(WID_OFFSET);
    localparam int unsigned       CTRL_USED = RUN_SEL_W + 1;

    logic [RUN_SEL_W-1:0] run_sel_q;
    logic                 stop_sel_q;
    logic [WIDTH_W-1:0]   width_q;

    // Capture writes; only power-on reset returns the fields to zero.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            run_sel_q  <= '0;
            stop_sel_q <= 1'b0;
            width_q    <= '0;
        end else if (wr_en_i) begin
            if (addr_i == CTRL_A) begin
                run_sel_q  <= wdata_i[RUN_SEL_W-1:0];
                stop_sel_q <= wdata_i[RUN_SEL_W];
            end else if (addr_i == WID_A) begin
                width_q <= wdata_i[WIDTH_W-1:0];
            end
        end
    end

    // Return the addressed fields, unused bits zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_A) begin
            rdata_o[RUN_SEL_W-1:0] = run_sel_q;
            rdata_o[RUN_SEL_W]     = stop_sel_q;
        end else if (addr_i == WID_A) begin
            rdata_o[WIDTH_W-1:0] = width_q;
        end
    end

    assign run_sel_o  = run_sel_q;
    assign stop_sel_o = stop_sel_q;
    assign width_o    = width_q;

    // R8: without a write the fields hold their value.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && !$past(wr_en_i)) |->
        ($stable(run_sel_o) && $stable(stop_sel_o) && $stable(width_o)));

    // R9: the control register shows zeros above its fields.
    p_ctrl_unused_r9: assert property (@(posedge clk) disable iff (!por_n)
        (addr_i == CTRL_A) |-> (rdata_o[DATA_W-1:CTRL_USED] == '0));
endmodule

// File: rtl/rstpin_filter.sv
// Reset pin glitch filter top: synchronizer, bus-clock and low-power filter
// engines, configuration registers and the power-mode path selection.
// Assumes: lp_tick is a one-cycle pulse in the bus clock domain; ll_stop
// overrides stop_mode; the datapath is reset by either rst_n or por_n.
module rstpin_filter #(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned WIDTH_W     = 5,
    parameter int unsigned LP_NEED     = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CTRL_OFFSET = 4,
    parameter int unsigned WID_OFFSET  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              pin_n,
    input  logic              lp_tick,
    input  logic              stop_mode,
    input  logic              ll_stop,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    import rpf_pkg::*;

    localparam int unsigned BUS_NEED_W = WIDTH_W + 1;
    localparam int unsigned LP_NEED_W  = $clog2(LP_NEED + 1);

    logic                  dp_rst_n;
    logic                  pin_sync;
    logic [RUN_SEL_W-1:0]  run_sel;
    logic                  stop_sel;
    logic [WIDTH_W-1:0]    width;
    eng_sel_e              eng_sel;
    logic [BUS_NEED_W-1:0] bus_need;
    logic                  bus_level;
    logic [BUS_NEED_W-1:0] bus_cnt;
    logic                  lp_level;
    logic [LP_NEED_W-1:0]  lp_cnt;

    assign dp_rst_n = rst_n & por_n;

    rpf_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (dp_rst_n),
        .d_i   (pin_n),
        .q_o   (pin_sync)
    );

    rpf_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDTH_W(WIDTH_W),
        .CTRL_OFFSET(CTRL_OFFSET), .WID_OFFSET(WID_OFFSET)
    ) u_cfg (
        .clk        (clk),
        .por_n      (por_n),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .run_sel_o  (run_sel),
        .stop_sel_o (stop_sel),
        .width_o    (width)
    );

    // Pick the active path from the power mode and the select fields.
    always_comb begin
        if (ll_stop) begin
            eng_sel = ENG_OFF;
        end else if (stop_mode) begin
            eng_sel = stop_sel ? ENG_LP : ENG_OFF;
        end else begin
            unique case (run_sel)
                RUN_CODE_BUS: eng_sel = ENG_BUS;
                RUN_CODE_LP:  eng_sel = ENG_LP;
                default:      eng_sel = ENG_OFF;
            endcase
        end
    end

    // Required run length of the bus-clock engine is the field plus one.
    always_comb begin
        bus_need = {1'b0, width} + BUS_NEED_W'(1);
    end

    rpf_count_filter #(.NEED_W(BUS_NEED_W)) u_bus_eng (
        .clk     (clk),
        .rst_n   (dp_rst_n),
        .clr_i   (eng_sel != ENG_BUS),
        .en_i    (1'b1),
        .smp_i   (pin_sync),
        .need_i  (bus_need),
        .level_o (bus_level),
        .cnt_o   (bus_cnt)
    );

    rpf_count_filter #(.NEED_W(LP_NEED_W)) u_lp_eng (
        .clk     (clk),
        .rst_n   (dp_rst_n),
        .clr_i   (eng_sel != ENG_LP),
        .en_i    (lp_tick),
        .smp_i   (pin_sync),
        .need_i  (LP_NEED_W'(LP_NEED)),
        .level_o (lp_level),
        .cnt_o   (lp_cnt)
    );

    // Drive the request from the selected path; pin low means request.
    always_comb begin
        unique case (eng_sel)
            ENG_BUS: rst_req = ~bus_level;
            ENG_LP:  rst_req = ~lp_level;
            default: rst_req = ~pin_sync;
        endcase
    end

    // R5: stop mode leaves the bus-clock engine idle.
    p_stop_bus_idle_r5: assert property (@(posedge clk) disable iff (!dp_rst_n)
        stop_mode |=> (bus_level && (bus_cnt == '0)));

    // R7: low-leakage stop leaves the low-power engine idle.
    p_ll_lp_idle_r7: assert property (@(posedge clk) disable iff (!dp_rst_n)
        ll_stop |=> (lp_level && (lp_cnt == '0)));
endmodule

// File: tb/rstpin_filter_tb_top.sv
// Self-checking bench: directed edge-exact checks plus seeded random
// stimulus compared cycle by cycle with a behavioural model.
module rstpin_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, por_n, pin_n, lp_tick, stop_mode, ll_stop, wr_en;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       rst_req;

    int n_checks = 0;
    int n_errors = 0;
    bit cmp_en   = 1'b0;

    always #4 clk = ~clk;

    rstpin_filter dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .pin_n(pin_n),
        .lp_tick(lp_tick), .stop_mode(stop_mode), .ll_stop(ll_stop),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rst_req(rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Behavioural model of the requirements.
    logic       m_s1, m_s2, m_bl, m_ll;
    int         m_bc, m_lc;
    logic [2:0] m_ctrl;
    logic [4:0] m_wid;

    function automatic int m_sel();
        if (ll_stop)   return 0;
        if (stop_mode) return m_ctrl[2] ? 2 : 0;
        if (m_ctrl[1:0] == 2'd1) return 1;
        if (m_ctrl[1:0] == 2'd2) return 2;
        return 0;
    endfunction

    function automatic logic m_req();
        int s = m_sel();
        if (s == 1) return !m_bl;
        if (s == 2) return !m_ll;
        return !m_s2;
    endfunction

    function automatic logic [7:0] m_rd(input logic [2:0] a);
        if (a == 3'd4) return {5'd0, m_ctrl};
        if (a == 3'd5) return {3'd0, m_wid};
        return 8'd0;
    endfunction

    always @(posedge clk) begin
        int s;
        s = m_sel();
        if (!rst_n || !por_n) begin
            m_s1 = 1; m_s2 = 1; m_bl = 1; m_bc = 0; m_ll = 1; m_lc = 0;
        end else begin
            if (s != 1) begin m_bl = 1; m_bc = 0; end
            else if (m_s2 == m_bl) m_bc = 0;
            else if (m_bc + 1 >= int'(m_wid) + 1) begin m_bl = m_s2; m_bc = 0; end
            else m_bc++;
            if (s != 2) begin m_ll = 1; m_lc = 0; end
            else if (lp_tick) begin
                if (m_s2 == m_ll) m_lc = 0;
                else if (m_lc + 1 >= 3) begin m_ll = m_s2; m_lc = 0; end
                else m_lc++;
            end
            m_s2 = m_s1; m_s1 = pin_n;
        end
        if (!por_n) begin m_ctrl = 0; m_wid = 0; end
        else if (wr_en) begin
            if (addr == 3'd4) m_ctrl = wdata[2:0];
            else if (addr == 3'd5) m_wid = wdata[4:0];
        end
    end

    // Continuous comparison away from the clock edge.
    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            check("R10 model", rst_req, m_req());
            check("R9 model", rdata, m_rd(addr));
        end
    end

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic read_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk); addr = a; #1;
        check(tag, rdata, exp);
    endtask

    // Drop the pin and require rst_req to rise exactly on edge n.
    task automatic expect_rise(input string tag, input int n);
        @(negedge clk); pin_n = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk); #1;
            check(tag, rst_req, k >= n);
        end
        @(negedge clk); pin_n = 1;
        repeat (45) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int hold;
        void'($urandom(32'd20240611));
        rst_n = 0; por_n = 0; pin_n = 1; lp_tick = 1; stop_mode = 0; ll_stop = 0;
        wr_en = 0; addr = 0; wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;
        @(negedge clk); #1;
        cmp_en = 1;
        check("R10 reset idle", rst_req, 0);
        read_chk("R8 por ctrl", 3'd4, 8'h00);
        read_chk("R8 por width", 3'd5, 8'h00);

        // Pass-through and reserved code.
        expect_rise("R1 passthrough", 2);
        write_reg(3'd4, 8'h03);
        expect_rise("R3 reserved", 2);

        // Bus-clock engine at several widths.
        write_reg(3'd4, 8'h01);
        write_reg(3'd5, 8'h00);
        expect_rise("R2 width0", 3);
        write_reg(3'd5, 8'h1F);
        expect_rise("R2 width31", 34);
        write_reg(3'd5, 8'h04);
        expect_rise("R2 width4", 7);
        // Glitch one sample too short.
        @(negedge clk); pin_n = 0;
        repeat (4) @(negedge clk);
        pin_n = 1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1; check("R2 glitch", rst_req, 0);
        end

        // Low-power engine.
        write_reg(3'd4, 8'h02);
        expect_rise("R4 lp", 5);
        write_reg(3'd4, 8'h03);
        write_reg(3'd4, 8'h02);
        @(negedge clk); lp_tick = 0; pin_n = 0;
        repeat (8) begin @(negedge clk); #1; check("R4 no tick", rst_req, 0); end
        lp_tick = 1;
        @(negedge clk); pin_n = 1;
        repeat (20) @(negedge clk);

        // Stop mode selection.
        write_reg(3'd4, 8'h01);
        @(negedge clk); stop_mode = 1;
        expect_rise("R5 stop off", 2);
        write_reg(3'd4, 8'h05);
        expect_rise("R5 stop lp", 5);
        stop_mode = 0;

        // Bus engine restarts after stop.
        write_reg(3'd5, 8'h09);
        @(negedge clk); lp_tick = 0; pin_n = 0;
        repeat (6) @(negedge clk);
        stop_mode = 1;
        repeat (2) @(negedge clk);
        stop_mode = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk); #1; check("R6 restart", rst_req, k >= 10);
        end
        @(negedge clk); pin_n = 1; lp_tick = 1;
        repeat (20) @(negedge clk);

        // Low-leakage stop.
        write_reg(3'd4, 8'h02);
        @(negedge clk); ll_stop = 1; stop_mode = 1; pin_n = 0;
        for (int k = 1; k <= 2; k++) begin
            @(negedge clk); #1; check("R7 ll pass", rst_req, k >= 2);
        end
        repeat (3) @(negedge clk);
        ll_stop = 0; stop_mode = 0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk); #1; check("R7 ll clear", rst_req, k >= 3);
        end
        @(negedge clk); pin_n = 1;
        repeat (20) @(negedge clk);

        // Configuration retention and register map.
        write_reg(3'd4, 8'h06);
        write_reg(3'd5, 8'h0A);
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        read_chk("R8 warm ctrl", 3'd4, 8'h06);
        read_chk("R8 warm width", 3'd5, 8'h0A);
        @(negedge clk); por_n = 0;
        repeat (2) @(negedge clk);
        por_n = 1;
        read_chk("R8 por clear ctrl", 3'd4, 8'h00);
        read_chk("R8 por clear width", 3'd5, 8'h00);
        write_reg(3'd4, 8'hFF);
        write_reg(3'd5, 8'hFF);
        write_reg(3'd6, 8'hFF);
        read_chk("R9 ctrl mask", 3'd4, 8'h07);
        read_chk("R9 width mask", 3'd5, 8'h1F);
        read_chk("R9 other", 3'd6, 8'h00);
        read_chk("R9 zero off", 3'd0, 8'h00);
        write_reg(3'd4, 8'h00);

        // Random phase.
        hold = 0;
        for (int cyc = 0; cyc < 5000; cyc++) begin
            @(negedge clk);
            if (hold == 0) begin pin_n = ~pin_n; hold = $urandom_range(0, 40); end
            else hold--;
            lp_tick = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 199) == 0) stop_mode = ~stop_mode;
            if (!stop_mode) ll_stop = 0;
            else if ($urandom_range(0, 299) == 0) ll_stop = ~ll_stop;
            wr_en = ($urandom_range(0, 79) == 0);
            addr  = 3'($urandom_range(3, 6));
            wdata = 8'($urandom);
            rst_n = ($urandom_range(0, 999) != 0);
        end
        @(negedge clk);
        wr_en = 0; rst_n = 1; pin_n = 1;
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule